// File: doc/BRIEF.md
# Interrupt Pin Capture and Delivery

This block watches a bank of interrupt input lines, keeps one pending bit for each of 24 interrupt pins, and turns serviced pins into 32-bit address / 32-bit data delivery messages. Each pin's behaviour comes from a 64-bit redirection entry. The entry table is kept outside the block and presented to it as one flat vector. When an input change calls for it, the block runs a service pass. The pass visits pending, unmasked pins from the lowest index upward. For each pin it visits, it either emits a message on a valid/ready output, or asks the entry owner to set that pin's remote-IRR bit, or does both.

Edge-triggered pins latch a request on a rising input and lose their pending bit once served. Level-triggered pins follow their input. Once served, a level pin stays blocked by remote-IRR until the owner of the table clears it. Input line 0 is steered onto pin 2, and input lines at or above the pin count go nowhere. For pins in external-controller delivery mode, the vector is taken from a dedicated input rather than from the entry.

Top module: `irq_dispatch`

## Requirements
- R1: Input line 0 acts as a request on pin 2, ORed with line 2; pin 0 never becomes pending; lines at or above the pin count (24) never cause a message or a remote-IRR pulse.
- R2: For a level-triggered pin (entry bit 15 = 1), a rising input sets the pending bit and a falling input clears it; a rise starts a service pass only when the entry's remote-IRR bit (bit 14) is 0.
- R3: For an edge-triggered pin (bit 15 = 0), a rising input sets the pending bit and starts a pass only when the mask bit (bit 16) is 0; a rise while masked is discarded, so unmasking later yields no message for it.
- R4: A service pass visits pending, unmasked pins in ascending pin order, one per visit, and skips masked or idle pins.
- R5: Serving an edge-triggered pin clears its pending bit, so a later pass does not repeat it unless a new rise arrives.
- R6: Serving a level-triggered pin raises that pin's bit of `rirr_set` for one cycle; if remote-IRR was already 1 when the pin is visited, no message is sent for it.
- R7: Entry layout: vector [7:0], delivery mode [10:8], destination mode [11], remote-IRR [14], trigger [15], mask [16], destination/index [63:48]. Message address = 0xFEE00000 | destination<<4 | destination-mode<<2; message data = vector | delivery-mode<<8 | trigger<<15.
- R8: When the delivery mode is 3'b111 (external controller), the data vector field is `ext_vec` sampled when the pin is served, not entry bits [7:0].
- R9: Messages leave one at a time; while `msg_valid` is high and `msg_ready` is low, address and data hold and the pass stalls, and every expected message is eventually delivered.
- R10: After reset no message is valid, no remote-IRR pulse is raised and no pin is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NIN (32) | Interrupt input levels |
| rte_flat | input | NPIN*64 (1536) | Redirection entries, pin p at bits [p*64+63 : p*64] |
| ext_vec | input | 8 | Vector supplied by the external controller |
| msg_ready | input | 1 | Message sink ready |
| msg_valid | output | 1 | Message valid |
| msg_addr | output | 32 | Message address |
| msg_data | output | 32 | Message data |
| rirr_set | output | NPIN (24) | One-cycle request to set remote-IRR, one bit per pin |

## Verification
The assertions take for granted three things about the environment. The entry table changes only when the block is quiet. The entry owner sets remote-IRR at the clock edge where `rirr_set` is seen. `msg_ready` is a plain input that may drop at any time. The stimulus follows these rules. It edits entries, including clearing remote-IRR to stand in for an end-of-interrupt, only between input batches, after the previous batch has fully drained. It updates its own copy of the table from every `rirr_set` pulse at the next rising edge. It also holds `msg_ready` low for random cycles during the long batches, so that back-pressure is exercised.

// File: rtl/irq_dispatch.sv
`timescale 1ns/1ps
module irq_dispatch #(
  parameter int          NPIN = 24,
  parameter int          NIN  = 32,
  parameter logic [31:0] BASE = 32'hFEE0_0000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NIN-1:0]       irq_in,
  input  logic [NPIN*64-1:0]   rte_flat,
  input  logic [7:0]           ext_vec,
  input  logic                 msg_ready,
  output logic                 msg_valid,
  output logic [31:0]          msg_addr,
  output logic [31:0]          msg_data,
  output logic [NPIN-1:0]      rirr_set
);
  localparam int IW = $clog2(NPIN);
  localparam logic [2:0] DM_EXT = 3'b111;

  logic [NPIN-1:0] eff, eff_q, rise, fall;
  logic [NPIN-1:0] trig_v, mask_v, rirr_v;
  logic [NPIN-1:0] pend, pend_set, visited, cand, sel_oh, clr;
  logic [IW-1:0]   sel;
  logic            has, kick, active, again;
  logic [63:0]     cur;
  logic            needs, slot_free, step, load;
  logic [7:0]      vec;

  always_comb begin
    eff    = irq_in[NPIN-1:0];
    eff[0] = 1'b0;
    eff[2] = irq_in[0] | irq_in[2];
    for (int i = 0; i < NPIN; i++) begin
      rirr_v[i] = rte_flat[i*64 + 14];
      trig_v[i] = rte_flat[i*64 + 15];
      mask_v[i] = rte_flat[i*64 + 16];
    end
  end

  assign rise     = eff & ~eff_q;
  assign fall     = ~eff & eff_q;
  assign pend_set = rise & (trig_v | ~mask_v);
  assign kick     = |(rise & ((trig_v & ~rirr_v) | (~trig_v & ~mask_v)));
  assign cand     = pend & ~mask_v & ~visited;

  always_comb begin
    sel = '0;
    has = 1'b0;
    for (int i = NPIN - 1; i >= 0; i--) begin
      if (cand[i]) begin
        sel = IW'(i);
        has = 1'b1;
      end
    end
  end

  assign cur       = rte_flat[int'(sel)*64 +: 64];
  assign needs     = !cur[15] || !cur[14];
  assign slot_free = !msg_valid || msg_ready;
  assign step      = active && has && (!needs || slot_free);
  assign load      = step && needs;
  assign sel_oh    = NPIN'(1) << sel;
  assign rirr_set  = (step &&  cur[15]) ? sel_oh : '0;
  assign clr       = (step && !cur[15]) ? sel_oh : '0;
  assign vec       = (cur[10:8] == DM_EXT) ? ext_vec : cur[7:0];

  logic unused_bits;
  assign unused_bits = ^{cur[47:17], cur[13:12], irq_in[NIN-1:NPIN]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eff_q   <= '0;
      pend    <= '0;
      visited <= '0;
      active  <= 1'b0;
      again   <= 1'b0;
    end else begin
      eff_q <= eff;
      pend  <= ((pend & ~clr) & ~(fall & trig_v)) | pend_set;
      if (!active) begin
        if (kick) begin
          active  <= 1'b1;
          visited <= '0;
        end
        again <= 1'b0;
      end else if (!has) begin
        visited <= '0;
        again   <= 1'b0;
        active  <= again | kick;
      end else begin
        if (step) visited[sel] <= 1'b1;
        if (kick) again <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else if (load) begin
      msg_valid <= 1'b1;
      msg_addr  <= BASE | (32'(cur[63:48]) << 4) | (32'(cur[11]) << 2);
      msg_data  <= {16'b0, cur[15], 4'b0, cur[10:8], vec};
    end else if (msg_ready) begin
      msg_valid <= 1'b0;
    end
  end

  a_r9_hold_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

  a_r6_single_rirr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rirr_set));

  a_r3_masked_edge_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & $past(rise & ~trig_v & mask_v & ~pend)) == '0));

  a_r2_level_fall_clears: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & $past(fall & trig_v)) == '0));

  a_r1_pin0_never_pending: assert property (@(posedge clk) disable iff (!rst_n)
    !pend[0]);
endmodule

// File: tb/sim_irq_dispatch.sv
`timescale 1ns/1ps
module sim_irq_dispatch;
  localparam int NPIN = 24;
  localparam int NIN  = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NIN-1:0] irq_in = '0;
  logic [63:0] tbl [NPIN];
  logic [NPIN*64-1:0] rte_flat;
  logic [7:0] ext_vec = 8'h00;
  logic msg_ready = 1'b0;
  logic msg_valid;
  logic [31:0] msg_addr, msg_data;
  logic [NPIN-1:0] rirr_set;

  int n_cmp = 0, n_bad = 0;
  bit stall_mode = 1'b0, done = 1'b0;
  string cur_tag = "R7";
  logic [63:0] exp_msgs[$];
  int exp_rirr[$];
  logic [NPIN-1:0] m_eff = '0, m_pend = '0;

  always #4 clk = ~clk;

  always_comb
    for (int p = 0; p < NPIN; p++) rte_flat[p*64 +: 64] = tbl[p];

  irq_dispatch u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .rte_flat(rte_flat),
    .ext_vec(ext_vec), .msg_ready(msg_ready), .msg_valid(msg_valid),
    .msg_addr(msg_addr), .msg_data(msg_data), .rirr_set(rirr_set)
  );

  function automatic logic [63:0] mk(logic [7:0] v, logic [2:0] dm, logic dmode,
                                     logic trig, logic mask, logic [15:0] dest);
    return {dest, 31'b0, mask, trig, 1'b0, 2'b0, dmode, dm, v};
  endfunction

  function automatic logic [63:0] expect_of(logic [63:0] e);
    logic [31:0] a, d;
    logic [7:0] v;
    v = (e[10:8] == 3'b111) ? ext_vec : e[7:0];
    a = 32'hFEE0_0000 | ({16'b0, e[63:48]} << 4) | ({31'b0, e[11]} << 2);
    d = {24'b0, v} | ({29'b0, e[10:8]} << 8) | ({31'b0, e[15]} << 15);
    return {a, d};
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk)
    for (int p = 0; p < NPIN; p++) if (rirr_set[p]) tbl[p][14] <= 1'b1;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      msg_ready = stall_mode ? ($urandom_range(0, 2) == 0) : 1'b1;
      if (msg_valid && msg_ready) begin
        if (exp_msgs.size() == 0) chk({cur_tag, " R9 unexpected message"}, {msg_addr, msg_data}, 64'h0);
        else chk({cur_tag, " R4 R7 message"}, {msg_addr, msg_data}, exp_msgs.pop_front());
      end
      for (int p = 0; p < NPIN; p++) begin
        if (rirr_set[p]) begin
          if (exp_rirr.size() == 0) chk({cur_tag, " R6 unexpected rirr pulse"}, 64'(p), 64'hFFFF);
          else chk({cur_tag, " R6 rirr pulse pin"}, 64'(p), 64'(exp_rirr.pop_front()));
        end
      end
    end
  end

  task automatic phase(input logic [NIN-1:0] v, input string tag);
    logic [NPIN-1:0] e;
    bit kick;
    kick = 1'b0;
    @(negedge clk);
    cur_tag = tag;
    e = v[NPIN-1:0];
    e[0] = 1'b0;
    e[2] = v[0] | v[2];
    for (int p = 0; p < NPIN; p++) begin
      if (e[p] && !m_eff[p]) begin
        if (tbl[p][15] || !tbl[p][16]) m_pend[p] = 1'b1;
        if (tbl[p][15] ? !tbl[p][14] : !tbl[p][16]) kick = 1'b1;
      end
      if (!e[p] && m_eff[p] && tbl[p][15]) m_pend[p] = 1'b0;
    end
    m_eff = e;
    if (kick) begin
      for (int p = 0; p < NPIN; p++) begin
        if (m_pend[p] && !tbl[p][16]) begin
          if (!tbl[p][15]) begin
            m_pend[p] = 1'b0;
            exp_msgs.push_back(expect_of(tbl[p]));
          end else begin
            if (!tbl[p][14]) exp_msgs.push_back(expect_of(tbl[p]));
            exp_rirr.push_back(p);
          end
        end
      end
    end
    irq_in = v;
    repeat (300) @(negedge clk);
    chk({tag, " R9 all messages delivered"}, 64'(exp_msgs.size()), 64'd0);
    chk({tag, " R6 all pulses seen"}, 64'(exp_rirr.size()), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    for (int p = 0; p < NPIN; p++)
      tbl[p] = mk(8'(8'h20 + p), 3'd0, p[0], 1'b0, 1'b0, 16'(16'h0100 + p));
    repeat (3) @(negedge clk);
    chk("R10 valid in reset", 64'(msg_valid), 64'd0);
    chk("R10 pulses in reset", 64'(rirr_set), 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 valid after reset", 64'(msg_valid), 64'd0);
    chk("R10 pulses after reset", 64'(rirr_set), 64'd0);

    phase(32'h0000_0228, "R4");
    phase(32'h0, "R4");
    phase(32'h0000_0001, "R1");
    phase(32'h4000_0000, "R1");
    phase(32'h0, "R1");

    tbl[7][16] = 1'b1;
    phase(32'h0000_0080, "R3");
    phase(32'h0, "R3");
    tbl[7][16] = 1'b0;
    phase(32'h0000_0010, "R3");
    phase(32'h0, "R3");

    phase(32'h0000_0040, "R5");
    phase(32'h0000_0140, "R5");
    phase(32'h0, "R5");

    tbl[10] = mk(8'h91, 3'd1, 1'b1, 1'b1, 1'b0, 16'hBEEF);
    phase(32'h0000_0400, "R2");
    phase(32'h0, "R2");
    phase(32'h0000_0400, "R2");
    phase(32'h0000_0C00, "R6");
    phase(32'h0000_0400, "R6");
    tbl[10][14] = 1'b0;
    phase(32'h0, "R2");
    phase(32'h0000_1000, "R2");
    phase(32'h0, "R2");
    phase(32'h0000_0400, "R6");
    phase(32'h0, "R6");

    ext_vec = 8'h5A;
    tbl[13] = mk(8'h33, 3'b111, 1'b0, 1'b0, 1'b0, 16'h00AB);
    tbl[14] = mk(8'h44, 3'b011, 1'b1, 1'b0, 1'b0, 16'hF00D);
    phase(32'h0000_6000, "R8");
    phase(32'h0, "R8");

    tbl[10] = mk(8'h2A, 3'd0, 1'b0, 1'b0, 1'b0, 16'h010A);
    stall_mode = 1'b1;
    phase(32'h00FF_FFFE, "R9");
    phase(32'h0, "R9");
    stall_mode = 1'b0;

    done = 1'b1;
    summary();
  end
endmodule